// File: doc/BRIEF.md
# Sign-Steered Index Chain Accumulator

This block follows a chain of table indices and totals the values found along the way. Three internal tables are loaded through a single write port before a run: one data table and two successor tables. A start pulse clears the running total and the current index. The block then performs a fixed number of iterations. Each iteration reads the data word at the current index, adds it into the total, and fetches the next index. The next index comes from the successor table for positive totals or from the one for non-positive totals, chosen by the sign of the total just formed.

Each next address depends on the total that the previous read produced, so one iteration cannot start before the previous one has finished. The block therefore runs one iteration every three cycles: a data read, an add and compare that also issues the chosen successor read, and an index update. When the last iteration has finished, a one-cycle done pulse is raised and the total stays on the output until the next start.

Top module: `chase_acc`

## Requirements
- R1: After reset, `sum` is 0 and `done` is 0.
- R2: A start accepted while idle clears the total and the current index to 0. Exactly ITERS iterations then follow. `done` is high in the cycle that follows the clock edge 3*ITERS edges after the edge that sampled start.
- R3: Each iteration adds the signed data word at the current index to the total, wrapping modulo 2^DATA_W.
- R4: After the add, the next index is read from the positive successor table when the new total, taken as signed, is greater than zero. Otherwise it is read from the negative successor table, and a total of exactly zero takes the negative table.
- R5: A start that arrives while a run is in progress has no effect on that run's result or on when it ends.
- R6: `done` is high for exactly one cycle per run. `sum` keeps its final value until the next accepted start.
- R7: A write with `wr_en` high stores to the table picked by `wr_tbl`: 0 is the data table (full `wr_data`), 1 is the positive successor table and 2 is the negative successor table (each takes the low IDX_W bits of `wr_data`). A write with code 3 changes no table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 2 | Table select for the write |
| wr_addr | input | IDX_W | Write address |
| wr_data | input | DATA_W | Write value |
| sum | output | DATA_W | Running and final total |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with DATA_W=16, IDX_W=4 and ITERS=100. The 16-entry tables let 100 iterations revisit indices many times and follow long sign-driven walks. The 16-bit total lets wrap-around arithmetic and sign flips caused by overflow happen within a handful of additions. With the narrow index, successor values and the zero-total tie case can be built by hand, while a full run still has the specified length.

// File: rtl/chase_acc_pkg.sv
package chase_acc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_ACC  = 2'd2,
      ST_NEXT = 2'd3
   } chase_st_e;

   localparam logic [1:0] TBL_DATA = 2'd0;
   localparam logic [1:0] TBL_POS  = 2'd1;
   localparam logic [1:0] TBL_NEG  = 2'd2;
endpackage

// File: rtl/chase_ram.sv
module chase_ram #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/chase_seq.sv
module chase_seq
   import chase_acc_pkg::*;
#(
   parameter int ITERS = 100
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output chase_st_e st,
   output logic      done
);
   localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st    <= ST_READ;
                  cnt_q <= '0;
               end
            end
            ST_READ: st <= ST_ACC;
            ST_ACC:  st <= ST_NEXT;
            ST_NEXT: begin
               if (last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  st    <= ST_READ;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chase_acc.sv
module chase_acc
   import chase_acc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8,
   parameter int ITERS  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_en,
   input  logic [1:0]        wr_tbl,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] sum,
   output logic              done
);
   localparam int N_SUCC = 2;

   if (ITERS < 1) begin : g_bad_iters
      $error("chase_acc: ITERS must be at least 1");
   end
   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("chase_acc: IDX_W must be within 1..16");
   end
   if (DATA_W < IDX_W) begin : g_bad_data
      $error("chase_acc: DATA_W must not be narrower than IDX_W");
   end

   chase_st_e                st;
   logic                     busy;
   logic signed [DATA_W-1:0] sum_q;
   logic signed [DATA_W-1:0] sum_nx;
   logic        [DATA_W-1:0] d_rd;
   logic        [IDX_W-1:0]  idx_q;
   logic        [IDX_W-1:0]  succ_rd [N_SUCC];
   logic                     pos_nx;
   logic                     took_pos_q;

   chase_seq #(.ITERS(ITERS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .st    (st),
      .done  (done)
   );

   assign busy = (st != ST_IDLE);

   chase_ram #(.AW(IDX_W), .DW(DATA_W)) u_data (
      .clk   (clk),
      .we    (wr_en && (wr_tbl == TBL_DATA)),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (st == ST_READ),
      .raddr (idx_q),
      .rdata (d_rd)
   );

   assign sum_nx = sum_q + $signed(d_rd);
   assign pos_nx = (sum_nx > 0);

   for (genvar g = 0; g < N_SUCC; g++) begin : g_succ
      localparam logic [1:0] CODE = (g == 0) ? TBL_POS : TBL_NEG;
      logic pick;
      assign pick = (g == 0) ? pos_nx : !pos_nx;
      chase_ram #(.AW(IDX_W), .DW(IDX_W)) u_tbl (
         .clk   (clk),
         .we    (wr_en && (wr_tbl == CODE)),
         .waddr (wr_addr),
         .wdata (wr_data[IDX_W-1:0]),
         .re    ((st == ST_ACC) && pick),
         .raddr (idx_q),
         .rdata (succ_rd[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q      <= '0;
         idx_q      <= '0;
         took_pos_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  sum_q <= '0;
                  idx_q <= '0;
               end
            end
            ST_ACC: begin
               sum_q      <= sum_nx;
               took_pos_q <= pos_nx;
            end
            ST_NEXT: idx_q <= took_pos_q ? succ_rd[0] : succ_rd[1];
            default: ;
         endcase
      end
   end

   assign sum = sum_q;
endmodule

// File: rtl/chase_acc_chk.sv
module chase_acc_chk #(
   parameter int DATA_W = 32,
   parameter int ITERS  = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] sum
);
   localparam int RUN_CYC = 3 * ITERS;
   localparam int LEN_W   = $clog2(RUN_CYC + 2);

   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == LEN_W'(RUN_CYC))); // R2
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R2
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (sum == '0)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(sum)); // R6
   AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && run_len < LEN_W'(RUN_CYC - 1)) |=> busy); // R5
endmodule

bind chase_acc chase_acc_chk #(.DATA_W(DATA_W), .ITERS(ITERS)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .sum   (sum)
);

// File: tb/tb_chase_acc.sv
`timescale 1ns/1ps
module tb_chase_acc;
   localparam int DW = 16;
   localparam int IW = 4;
   localparam int NI = 100;
   localparam int DEP = 1 << IW;
   localparam int LAT = 3 * NI + 1;

   // {data slope, data offset, positive step, negative stride}
   localparam int NV = 6;
   localparam logic [39:0] VECS [NV] = '{
      {16'd3,     16'hFFF0, 4'd1,  4'd3},
      {16'd0,     16'h4000, 4'd0,  4'd0},
      {16'hFFFF,  16'd7,    4'd5,  4'd7},
      {16'h1234,  16'h8000, 4'd3,  4'd5},
      {16'd0,     16'd0,    4'd1,  4'd2},
      {16'd7,     16'hFFFB, 4'd15, 4'd11}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_tbl = '0;
   logic [IW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] sum;
   logic          done;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] m_data [DEP];
   logic [IW-1:0] m_pos  [DEP];
   logic [IW-1:0] m_neg  [DEP];

   always #2 clk = ~clk;

   chase_acc #(.DATA_W(DW), .IDX_W(IW), .ITERS(NI)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
      .wr_tbl(wr_tbl), .wr_addr(wr_addr), .wr_data(wr_data),
      .sum(sum), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] t, input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_tbl = t; wr_addr = IW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (t == 2'd0) m_data[a] = d;
      if (t == 2'd1) m_pos[a]  = d[IW-1:0];
      if (t == 2'd2) m_neg[a]  = d[IW-1:0];
   endtask

   function automatic logic [DW-1:0] model();
      logic signed [DW-1:0] s = '0;
      logic [IW-1:0] ix = '0;
      for (int k = 0; k < NI; k++) begin
         s  = s + $signed(m_data[ix]);
         ix = (s > 0) ? m_pos[ix] : m_neg[ix];
      end
      return s;
   endfunction

   // start on a negedge, count edges until done is seen high
   task automatic run(input bit mid_start, output int lat);
      @(negedge clk);
      start = 1'b1;
      lat = 0;
      while (lat < 2000) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = mid_start && (lat == 50);
         if (done) break;
      end
      start = 1'b0;
   endtask

   initial begin
      #(4ns * 200000);
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int lat;
      logic [DW-1:0] held;
      repeat (3) @(negedge clk);
      chk("R1 sum after reset", 32'(sum), 0);
      chk("R1 done after reset", 32'(done), 0);
      rst_n = 1'b1;

      // R2 R3 R4: vector walk
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < DEP; i++) begin
            wr(2'd0, i, DW'(i) * VECS[v][39:24] + VECS[v][23:8]);
            wr(2'd1, i, DW'((i + int'(VECS[v][7:4])) % DEP));
            wr(2'd2, i, DW'((i * int'(VECS[v][3:0]) + 1) % DEP));
         end
         run(1'b0, lat);
         chk($sformatf("R2 latency vec %0d", v), 32'(lat), 32'(LAT));
         chk($sformatf("R3 R4 sum vec %0d", v), 32'(sum), 32'(model()));
      end

      // R6: pulse width and hold
      held = sum;
      @(negedge clk);
      chk("R6 done single cycle", 32'(done), 0);
      repeat (20) @(negedge clk);
      chk("R6 sum held", 32'(sum), 32'(held));

      // R5: start during run ignored
      run(1'b1, lat);
      chk("R5 latency with extra start", 32'(lat), 32'(LAT));
      chk("R5 sum with extra start", 32'(sum), 32'(model()));

      // R7: code 3 writes nothing; R2 restart from nonzero total
      for (int i = 0; i < DEP; i++) wr(2'd3, i, 16'h7FFF);
      run(1'b0, lat);
      chk("R7 code 3 ignored", 32'(sum), 32'(model()));

      // R4: zero total must take the negative table
      for (int i = 0; i < DEP; i++) begin
         wr(2'd0, i, (i == 1) ? 16'd5 : 16'd0);
         wr(2'd1, i, 16'd1);
         wr(2'd2, i, 16'd0);
      end
      run(1'b0, lat);
      chk("R4 zero total uses negative table", 32'(sum), 0);

      // R3: wrap from the positive edge
      for (int i = 0; i < DEP; i++) begin
         wr(2'd0, i, 16'h0400);
         wr(2'd1, i, 16'd0);
         wr(2'd2, i, 16'd0);
      end
      run(1'b0, lat);
      chk("R3 wrapping total", 32'(sum), 32'(16'(NI * 16'h0400)));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule